// File: doc/BRIEF.md
# CPU Interrupt Mode Controller

This block sits next to a small 8-bit processor core and decides when and how the core is diverted into an interrupt service routine. It watches an active-low, level-sensitive maskable request and a falling-edge non-maskable request. It acts only at instruction boundaries, which the core signals with a one-cycle strobe. When it accepts a request, it updates the two enable flags and then plays out a short, fixed sequence of beats. The possible beats are an acknowledge cycle (M1 and IORQ together), a request to push the program counter, reads from a vector table, and a jump beat that carries the new program counter.

The maskable request has three selectable behaviours. In mode 0 the block only acknowledges, and the core executes the restart or call byte that the peripheral places on the bus. In mode 1 the block pushes PC and jumps to the fixed address 0x0038. In mode 2 the block acknowledges and reads a vector byte, forcing its bit 0 to 0. It then forms a table pointer with the I register as the high byte, reads a 16-bit service address from the pointer and from the pointer plus one (low byte first), pushes PC and jumps there. A non-maskable request is held in a latch until it is serviced. It outranks the maskable request, ignores the enable flag, pushes PC and jumps to 0x0066. It also saves the primary enable flag so that a return instruction can restore it.

The sequencer has these states:
- `ST_IDLE` waits for a boundary.
- `ST_ACK_BUS` is the mode 0 acknowledge.
- `ST_ACK_VEC` is the mode 2 acknowledge, which captures the vector.
- `ST_PUSH` is the push request.
- `ST_RD_LO` and `ST_RD_HI` are the table reads.
- `ST_JUMP` is the redirect beat.

Its transitions are:
- IDLE→PUSH for a non-maskable entry or a mode 1 entry.
- IDLE→ACK_BUS for a mode 0 entry.
- IDLE→ACK_VEC for a mode 2 entry.
- ACK_BUS→IDLE.
- ACK_VEC→PUSH.
- PUSH→RD_LO for a table entry; otherwise PUSH→JUMP.
- RD_LO→RD_HI.
- RD_HI→JUMP.
- JUMP→IDLE.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After reset, both enable flags read 0, the mode output reads 0, and the ack, push, read and jump outputs are all low.
- R2: The enable strobe sets both flags to 1 and the disable strobe clears both. A flag update caused by an interrupt entry takes precedence over these strobes in the same cycle.
- R3: The three mode strobes select the mode output code 0, 1 or 2, and the selection holds until another mode strobe arrives.
- R4: A maskable entry starts only on a clock edge where the boundary strobe is high, the sequencer is idle, `irq_en1` is 1 and `int_n` is 0. Otherwise nothing is started. The entry clears both flags.
- R5: A mode 0 entry produces exactly one cycle, one cycle after the boundary edge, with `ack_m1` and `ack_iorq` both high. No push, read or jump beat follows.
- R6: A mode 1 entry produces no acknowledge. `push_pc` is high for one cycle, and in the next cycle `jump_valid` is high with `jump_addr` = 0x0038.
- R7: A mode 2 entry plays these beats in order, one cycle each:
  - an acknowledge cycle, at whose end `bus_data` is captured with bit 0 forced to 0 as the pointer low byte, with `i_reg` as the high byte;
  - a push;
  - a read with `mem_addr` = pointer;
  - a read with `mem_addr` = pointer+1;
  - a jump to {byte read second, byte read first}.
- R8: A falling edge on `nmi_n` is latched and taken at the next boundary, whatever the state of `irq_en1`. At that entry the latch is cleared, `irq_en2` takes the old `irq_en1`, and `irq_en1` is cleared. The sequence is a push followed by a jump to 0x0066.
- R9: Either return strobe copies `irq_en2` into `irq_en1` and leaves `irq_en2` unchanged.
- R10: While a sequence is in progress, boundary strobes start no new entry. At most one of ack, push, read and jump is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_n | input | 1 | Maskable request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| instr_done | input | 1 | One-cycle strobe at an instruction boundary |
| op_ei | input | 1 | Decoded enable-interrupts strobe |
| op_di | input | 1 | Decoded disable-interrupts strobe |
| op_im0 | input | 1 | Decoded select-mode-0 strobe |
| op_im1 | input | 1 | Decoded select-mode-1 strobe |
| op_im2 | input | 1 | Decoded select-mode-2 strobe |
| op_reti | input | 1 | Decoded return-from-maskable strobe |
| op_retn | input | 1 | Decoded return-from-non-maskable strobe |
| i_reg | input | 8 | I register value, pointer high byte |
| bus_data | input | 8 | Peripheral vector byte or table read data |
| ack_m1 | output | 1 | M1 part of the acknowledge cycle |
| ack_iorq | output | 1 | IORQ part of the acknowledge cycle |
| push_pc | output | 1 | Request to push the program counter |
| mem_rd | output | 1 | Table read strobe |
| mem_addr | output | 16 | Table read address, 0 when idle |
| jump_valid | output | 1 | Redirect beat |
| jump_addr | output | 16 | New program counter, 0 when not valid |
| irq_en1 | output | 1 | Primary interrupt enable flag |
| irq_en2 | output | 1 | Saved enable flag |
| im_mode | output | 2 | Current maskable mode code |

## Verification
The assertions check the following on every cycle:
- the flag hand-over at a non-maskable entry, and the restore on return;
- the clearing of both flags at a maskable entry;
- the persistence of a latched edge;
- the rule that a push is always followed by a read or a jump;
- the even first table address;
- the rule that at most one action beat is active in a cycle.

The bench's scenarios are the only place where the exact order and values are shown:
- the full beat order and values of each mode;
- the fixed targets;
- the assembled table address;
- a pulse shorter than an instruction being held until the boundary;
- a boundary strobe during a sequence being ignored;
- the non-maskable request winning over a simultaneous maskable one.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK_BUS,
        ST_ACK_VEC,
        ST_PUSH,
        ST_RD_LO,
        ST_RD_HI,
        ST_JUMP
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_NMI,
        SRC_FIX,
        SRC_TAB
    } entry_src_t;

    typedef enum logic [1:0] {
        IM_0 = 2'd0,
        IM_1 = 2'd1,
        IM_2 = 2'd2
    } im_mode_t;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    logic nmi_q;
    logic fall;

    assign fall = nmi_q && !nmi_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            if (fall)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    AST_EDGE_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |=> pend); // R8
    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend); // R8

endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_ei,
    input  logic     op_di,
    input  logic     op_im0,
    input  logic     op_im1,
    input  logic     op_im2,
    input  logic     op_reti,
    input  logic     op_retn,
    input  logic     take_nmi,
    input  logic     take_int,
    output logic     iff1,
    output logic     iff2,
    output im_mode_t mode
);
    logic ret_any;
    assign ret_any = op_reti || op_retn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            mode <= IM_0;
        end else begin
            if (take_nmi) begin
                iff2 <= iff1;
                iff1 <= 1'b0;
            end else if (take_int) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (ret_any) begin
                iff1 <= iff2;
            end else if (op_ei) begin
                iff1 <= 1'b1;
                iff2 <= 1'b1;
            end else if (op_di) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end

            if (op_im2)
                mode <= IM_2;
            else if (op_im1)
                mode <= IM_1;
            else if (op_im0)
                mode <= IM_0;
        end
    end

    AST_NMI_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!iff1 && (iff2 == $past(iff1)))); // R8
    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_any && !take_nmi && !take_int) |=> (iff1 == $past(iff2))); // R9

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 2 * DATA_W,
    parameter logic [15:0] VEC_FIXED = 16'h0038,
    parameter logic [15:0] VEC_NMI   = 16'h0066
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_done,
    input  logic              nmi_pend,
    input  logic              int_req,
    input  im_mode_t          mode,
    input  logic [DATA_W-1:0] i_reg,
    input  logic [DATA_W-1:0] bus_data,
    output logic              take_nmi,
    output logic              take_int,
    output logic              ack_m1,
    output logic              ack_iorq,
    output logic              push_pc,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              jump_valid,
    output logic [ADDR_W-1:0] jump_addr
);
    seq_state_t        state, state_nx;
    entry_src_t        src, src_nx;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic              idle;

    assign idle     = (state == ST_IDLE);
    assign take_nmi = idle && instr_done && nmi_pend;
    assign take_int = idle && instr_done && !nmi_pend && int_req;

    // next-state decision
    always_comb begin
        state_nx = state;
        src_nx   = src;
        unique case (state)
            ST_IDLE: begin
                if (take_nmi) begin
                    state_nx = ST_PUSH;
                    src_nx   = SRC_NMI;
                end else if (take_int) begin
                    unique case (mode)
                        IM_1: begin
                            state_nx = ST_PUSH;
                            src_nx   = SRC_FIX;
                        end
                        IM_2: begin
                            state_nx = ST_ACK_VEC;
                            src_nx   = SRC_TAB;
                        end
                        default: state_nx = ST_ACK_BUS;
                    endcase
                end
            end
            ST_ACK_BUS: state_nx = ST_IDLE;
            ST_ACK_VEC: state_nx = ST_PUSH;
            ST_PUSH:    state_nx = (src == SRC_TAB) ? ST_RD_LO : ST_JUMP;
            ST_RD_LO:   state_nx = ST_RD_HI;
            ST_RD_HI:   state_nx = ST_JUMP;
            ST_JUMP:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            src   <= SRC_NMI;
            ptr   <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            state <= state_nx;
            src   <= src_nx;
            if (state == ST_ACK_VEC)
                ptr <= {i_reg, bus_data[DATA_W-1:1], 1'b0};
            if (state == ST_RD_LO)
                lo_q <= bus_data;
            if (state == ST_RD_HI)
                hi_q <= bus_data;
        end
    end

    // outputs decoded from state
    always_comb begin
        ack_m1     = 1'b0;
        ack_iorq   = 1'b0;
        push_pc    = 1'b0;
        mem_rd     = 1'b0;
        mem_addr   = '0;
        jump_valid = 1'b0;
        jump_addr  = '0;
        unique case (state)
            ST_ACK_BUS, ST_ACK_VEC: begin
                ack_m1   = 1'b1;
                ack_iorq = 1'b1;
            end
            ST_PUSH: push_pc = 1'b1;
            ST_RD_LO: begin
                mem_rd   = 1'b1;
                mem_addr = ptr;
            end
            ST_RD_HI: begin
                mem_rd   = 1'b1;
                mem_addr = ptr + 1'b1;
            end
            ST_JUMP: begin
                jump_valid = 1'b1;
                unique case (src)
                    SRC_NMI: jump_addr = VEC_NMI[ADDR_W-1:0];
                    SRC_FIX: jump_addr = VEC_FIXED[ADDR_W-1:0];
                    default: jump_addr = {hi_q, lo_q};
                endcase
            end
            default: ;
        endcase
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_m1, push_pc, mem_rd, jump_valid})); // R10
    AST_PUSH_THEN_GO: assert property (@(posedge clk) disable iff (!rst_n)
        push_pc |=> (jump_valid || mem_rd)); // R6
    AST_PTR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(push_pc)) |-> !mem_addr[0]); // R7

endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_n,
    input  logic              nmi_n,
    input  logic              instr_done,
    input  logic              op_ei,
    input  logic              op_di,
    input  logic              op_im0,
    input  logic              op_im1,
    input  logic              op_im2,
    input  logic              op_reti,
    input  logic              op_retn,
    input  logic [DATA_W-1:0] i_reg,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ack_m1,
    output logic              ack_iorq,
    output logic              push_pc,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              jump_valid,
    output logic [ADDR_W-1:0] jump_addr,
    output logic              irq_en1,
    output logic              irq_en2,
    output logic [1:0]        im_mode
);
    logic     nmi_pend;
    logic     take_nmi;
    logic     take_int;
    im_mode_t mode;

    assign im_mode = mode;

    irq_nmi_latch u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (take_nmi),
        .pend  (nmi_pend)
    );

    irq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_ei    (op_ei),
        .op_di    (op_di),
        .op_im0   (op_im0),
        .op_im1   (op_im1),
        .op_im2   (op_im2),
        .op_reti  (op_reti),
        .op_retn  (op_retn),
        .take_nmi (take_nmi),
        .take_int (take_int),
        .iff1     (irq_en1),
        .iff2     (irq_en2),
        .mode     (mode)
    );

    irq_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .nmi_pend   (nmi_pend),
        .int_req    (irq_en1 && !int_n),
        .mode       (mode),
        .i_reg      (i_reg),
        .bus_data   (bus_data),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .ack_m1     (ack_m1),
        .ack_iorq   (ack_iorq),
        .push_pc    (push_pc),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .jump_valid (jump_valid),
        .jump_addr  (jump_addr)
    );

    AST_INT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> (!irq_en1 && !irq_en2)); // R4
    AST_NMI_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi && nmi_n) |=> !nmi_pend); // R8

endmodule

// File: tb/sim_irq_mode_ctrl.sv
module sim_irq_mode_ctrl;

    typedef struct packed {
        logic        m1;
        logic        iorq;
        logic        push;
        logic        rd;
        logic [15:0] addr;
        logic        jv;
        logic [15:0] ja;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_n = 1'b1, nmi_n = 1'b1, instr_done = 1'b0;
    logic        op_ei = 0, op_di = 0, op_im0 = 0, op_im1 = 0, op_im2 = 0;
    logic        op_reti = 0, op_retn = 0;
    logic [7:0]  i_reg = 8'h00;
    logic [7:0]  vec_byte = 8'hFF;
    logic [7:0]  bus_data;
    logic        ack_m1, ack_iorq, push_pc, mem_rd, jump_valid;
    logic [15:0] mem_addr, jump_addr;
    logic        irq_en1, irq_en2;
    logic [1:0]  im_mode;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign bus_data = ack_iorq ? vec_byte : (mem_rd ? memf(mem_addr) : 8'hFF);

    irq_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n),
        .instr_done(instr_done), .op_ei(op_ei), .op_di(op_di),
        .op_im0(op_im0), .op_im1(op_im1), .op_im2(op_im2),
        .op_reti(op_reti), .op_retn(op_retn), .i_reg(i_reg),
        .bus_data(bus_data), .ack_m1(ack_m1), .ack_iorq(ack_iorq),
        .push_pc(push_pc), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .jump_valid(jump_valid), .jump_addr(jump_addr),
        .irq_en1(irq_en1), .irq_en2(irq_en2), .im_mode(im_mode)
    );

    // ---------------- reference model ----------------
    beat_t plan[$];
    beat_t cur = '0;
    logic  m_iff1 = 0, m_iff2 = 0, m_pend = 0, m_prev = 1;
    int    m_mode = 0;

    function automatic beat_t mk(logic m, logic p, logic r, logic [15:0] a,
                                 logic j, logic [15:0] ja);
        beat_t b;
        b.m1 = m; b.iorq = m; b.push = p; b.rd = r; b.addr = a;
        b.jv = j; b.ja = ja;
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            plan.delete();
            cur = '0; m_iff1 = 0; m_iff2 = 0; m_pend = 0; m_prev = 1; m_mode = 0;
        end else begin
            logic in_idle, t_nmi, t_int, fall;
            logic [15:0] p;
            in_idle = (plan.size() == 0) && (cur == '0);
            t_nmi = in_idle && instr_done && m_pend;
            t_int = in_idle && instr_done && !m_pend && m_iff1 && !int_n;
            if (t_nmi) begin
                plan.push_back(mk(0, 1, 0, 16'h0, 0, 16'h0));
                plan.push_back(mk(0, 0, 0, 16'h0, 1, 16'h0066));
            end else if (t_int) begin
                if (m_mode == 1) begin
                    plan.push_back(mk(0, 1, 0, 16'h0, 0, 16'h0));
                    plan.push_back(mk(0, 0, 0, 16'h0, 1, 16'h0038));
                end else if (m_mode == 2) begin
                    p = {i_reg, vec_byte[7:1], 1'b0};
                    plan.push_back(mk(1, 0, 0, 16'h0, 0, 16'h0));
                    plan.push_back(mk(0, 1, 0, 16'h0, 0, 16'h0));
                    plan.push_back(mk(0, 0, 1, p, 0, 16'h0));
                    plan.push_back(mk(0, 0, 1, p + 16'd1, 0, 16'h0));
                    plan.push_back(mk(0, 0, 0, 16'h0, 1, {memf(p + 16'd1), memf(p)}));
                end else begin
                    plan.push_back(mk(1, 0, 0, 16'h0, 0, 16'h0));
                end
            end
            cur = (plan.size() > 0) ? plan.pop_front() : '0;
            // flags
            if (t_nmi) begin m_iff2 = m_iff1; m_iff1 = 0; end
            else if (t_int) begin m_iff1 = 0; m_iff2 = 0; end
            else if (op_reti || op_retn) m_iff1 = m_iff2;
            else if (op_ei) begin m_iff1 = 1; m_iff2 = 1; end
            else if (op_di) begin m_iff1 = 0; m_iff2 = 0; end
            if (op_im2) m_mode = 2; else if (op_im1) m_mode = 1; else if (op_im0) m_mode = 0;
            fall = m_prev && !nmi_n;
            if (fall) m_pend = 1; else if (t_nmi) m_pend = 0;
            m_prev = nmi_n;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 R7 acknowledge", {ack_m1, ack_iorq}, {cur.m1, cur.iorq});
            chk("R4 R6 R8 push", push_pc, cur.push);
            chk("R7 table read", {mem_rd, mem_addr}, {cur.rd, cur.addr});
            chk("R6 R7 R8 jump", {jump_valid, jump_addr}, {cur.jv, cur.ja});
            chk("R2 R4 R8 R9 flags", {irq_en1, irq_en2}, {m_iff1, m_iff2});
            chk("R3 mode", im_mode, m_mode[1:0]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk); instr_done = 1;
        @(negedge clk); instr_done = 0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: op_ei = 1; 1: op_di = 1; 2: op_im0 = 1; 3: op_im1 = 1;
            4: op_im2 = 1; 5: op_reti = 1; default: op_retn = 1;
        endcase
        @(negedge clk);
        op_ei = 0; op_di = 0; op_im0 = 0; op_im1 = 0; op_im2 = 0;
        op_reti = 0; op_retn = 0;
    endtask

    task automatic run();
        idle(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {irq_en1, irq_en2}, 2'b00);
        chk("R1 mode", im_mode, 2'd0);
        chk("R1 outputs", {ack_m1, ack_iorq, push_pc, mem_rd, jump_valid}, 5'b0);
        // R4 masked request is not taken
        int_n = 0; boundary(); idle(3);
        // R4 enabled but request not at a boundary
        int_n = 1; strobe(0); int_n = 0; idle(3);
        // R5 mode 0
        boundary(); idle(4);
        // R6 mode 1
        strobe(3); strobe(0); boundary(); idle(4);
        // R7 mode 2 with odd vector; R10 boundary during sequence
        i_reg = 8'h12; vec_byte = 8'hA7;
        strobe(4); strobe(0); boundary(); boundary(); idle(6);
        // R7 second table entry, different I value
        i_reg = 8'hC0; vec_byte = 8'h40;
        strobe(0); boundary(); idle(7);
        // R8 short pulse while disabled, taken at later boundary
        int_n = 1;
        @(negedge clk); nmi_n = 0; @(negedge clk); nmi_n = 1; idle(4);
        boundary(); idle(4);
        // R8 R9 save with enable set, then return restores
        strobe(0);
        @(negedge clk); nmi_n = 0; idle(2);
        boundary(); idle(4); nmi_n = 1;
        strobe(6); idle(2);
        // R8 priority over maskable request
        strobe(3); int_n = 0;
        @(negedge clk); nmi_n = 0; idle(1);
        boundary(); idle(4); nmi_n = 1; int_n = 1;
        // R9 reti restores, R2 disable
        strobe(5); idle(1);
        strobe(1); idle(2);
        // R3 mode back to 0
        strobe(2); idle(2);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog act=running exp=finished");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule